// File: doc/BRIEF.md
# End-to-End Protection Tuple Generator

This block sits in the write path of a storage controller and fills in end-to-end protection information on the fly. Bytes arrive one per cycle on a valid/ready stream. Each logical block on the stream is a run of data bytes followed by a run of metadata bytes. Inside the metadata region the block replaces a fixed-size field with a protection tuple. The tuple holds a guard CRC computed over the bytes that precede it, an application tag, and a reference tag. All other bytes pass through unchanged.

Two tuple formats are available. The narrow format is 8 bytes and carries a 16-bit CRC guard. The wide format is 16 bytes and carries a 64-bit CRC guard with a 48-bit reference tag. The tuple can sit at the start or at the end of the metadata. In tail placement, the guard also covers the metadata bytes that come before the tuple. The reference tag advances once per logical block unless the protection type is 3. A zero-fill mode writes the tags as usual but puts a fixed guard value in place of the computed CRC.

The configuration inputs are read on the byte that carries `s_first`, which starts a command, and are held inside for the rest of that command. The output port is a same-cycle view of the input port:
- `m_valid` follows `s_valid`.
- `s_ready` follows `m_ready`, so back-pressure from downstream stalls the upstream source directly.
- A byte is consumed only on a cycle where `s_valid` and `m_ready` are both high.

Top module: `pi_tuple_gen`

## Requirements
- R1: Bytes outside the tuple field leave on `m_data` in the same cycle they arrive, unchanged. `m_valid` equals `s_valid`, `m_last` equals `s_last`, and with `s_valid` low `m_valid` is low.
- R2: With `cfg_wide`=0, tuple bytes 0..1 carry the 16-bit guard, most significant byte first. The guard is a CRC with polynomial 0x8BB7 and initial value 0, shifted MSB-first, over the bytes of the logical block that precede the tuple. The CRC of ASCII "123456789" is 0xD0DB.
- R3: With `cfg_wide`=1, tuple bytes 0..7 carry the 64-bit guard, most significant byte first. The guard is a bit-reflected CRC with polynomial 0x9A6C9329AC4BC9B5, an all-ones start value and a final XOR with all ones, over the same byte range as in R2. The CRC of ASCII "123456789" is 0xAE8B14860A799888.
- R4: The tuple size T is 8 when `cfg_wide`=0 and 16 when `cfg_wide`=1.
  - With `cfg_head`=1, the tuple occupies block bytes `cfg_lbs` .. `cfg_lbs`+T-1, and the guard covers the data bytes only.
  - With `cfg_head`=0, the tuple occupies the last T bytes of the block, and the guard covers the data bytes plus the first `cfg_ms`-T metadata bytes.
  - Metadata bytes outside the tuple pass through unchanged.
- R5: The application tag is written most significant byte first. In the narrow format it occupies tuple bytes 2..3. In the wide format it occupies tuple bytes 8..9.
- R6: The reference tag is written most significant byte first. In the narrow format it is 32 bits in tuple bytes 4..7. In the wide format it is 48 bits in tuple bytes 10..15. The first block of a command uses `cfg_ref_tag`. Each later block uses the previous value plus one when `cfg_type` is 1 or 2, and the same value when `cfg_type` is 3.
- R7: The reference tag counts modulo 2^32 in the narrow format, with the upper bits of `cfg_ref_tag` ignored. It counts modulo 2^48 in the wide format.
- R8: With `cfg_zero_fill`=1, the guard field is written without reference to the data. It is 0x0000 in the narrow format and 0x6482D367EB22B64E in the wide format. The tags behave as in R5 to R7.
- R9: All `cfg_*` inputs are sampled only on the accepted byte with `s_first`=1. Changes on later bytes of the command have no effect on the output.
- R10: `s_ready` equals `m_ready`. While no byte is accepted, the block position, guard and tag state hold, so a stalled byte leaves unchanged once accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wide | input | 1 | 0: 8-byte tuple with 16-bit guard; 1: 16-byte tuple with 64-bit guard |
| cfg_type | input | 2 | Protection type 1, 2 or 3 |
| cfg_head | input | 1 | 1: tuple in the first metadata bytes; 0: in the last |
| cfg_zero_fill | input | 1 | Write the fixed guard instead of the computed CRC |
| cfg_lbs | input | LBS_W | Data bytes per logical block (at least 1) |
| cfg_ms | input | MS_W | Metadata bytes per logical block (at least the tuple size) |
| cfg_app_tag | input | 16 | Application tag |
| cfg_ref_tag | input | 48 | Reference tag of the first block |
| s_valid | input | 1 | Input byte valid |
| s_ready | output | 1 | Input byte accepted when high with `s_valid` |
| s_data | input | 8 | Input byte |
| s_first | input | 1 | First byte of a command |
| s_last | input | 1 | Last byte of a logical block (passed through) |
| m_valid | output | 1 | Output byte valid |
| m_ready | input | 1 | Downstream ready |
| m_data | output | 8 | Output byte |
| m_last | output | 1 | Last byte of a logical block |

## Verification
Each output byte is due in the same cycle as its input byte, so every result has zero cycles of latency. The bench drives a byte just after a falling edge and compares `m_data`, `m_last` and `s_ready` 1 ns later, before the next rising edge. Guard, position and tag state advance only on the rising edge that completes a handshake. The expected value of every byte therefore depends only on the bytes accepted before it, and the bench counts those itself while it holds bytes across random stall cycles.

// File: rtl/pi_pkg.sv
package pi_pkg;

  localparam logic [15:0] CRC16_POLY  = 16'h8BB7;
  localparam logic [63:0] CRC64_POLY  = 64'h9A6C9329AC4BC9B5;
  localparam logic [63:0] ZF_GUARD64  = 64'h6482D367EB22B64E;

  typedef struct packed {
    logic        wide;
    logic [1:0]  ptype;
    logic        head;
    logic        zf;
    logic [15:0] app;
  } cmd_cfg_t;

  function automatic logic [15:0] crc16_step(logic [15:0] c, logic [7:0] d);
    logic [15:0] x;
    x = c ^ {d, 8'h00};
    for (int b = 0; b < 8; b++)
      x = x[15] ? ((x << 1) ^ CRC16_POLY) : (x << 1);
    return x;
  endfunction

  function automatic logic [63:0] crc64_step(logic [63:0] c, logic [7:0] d);
    logic [63:0] x;
    x = c ^ {56'h0, d};
    for (int b = 0; b < 8; b++)
      x = x[0] ? ((x >> 1) ^ CRC64_POLY) : (x >> 1);
    return x;
  endfunction

endpackage

// File: rtl/pi_pos_ctl.sv
module pi_pos_ctl #(
  parameter int LBS_W = 16,
  parameter int MS_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic             first,
  input  logic [LBS_W-1:0] lbs,
  input  logic [MS_W-1:0]  ms,
  input  logic             wide,
  input  logic             head,
  output logic             blk_start,
  output logic             blk_end,
  output logic             crc_en,
  output logic             in_tuple,
  output logic [3:0]       tidx
);
  localparam int POS_W = ((LBS_W > MS_W) ? LBS_W : MS_W) + 1;

  logic [POS_W-1:0] pos_q, pos_cur, tsz, pil, tstart, blk_len, rel;

  always_comb begin
    pos_cur   = first ? '0 : pos_q;
    tsz       = wide ? POS_W'(16) : POS_W'(8);
    pil       = head ? '0 : (POS_W'(ms) - tsz);
    tstart    = POS_W'(lbs) + pil;
    blk_len   = POS_W'(lbs) + POS_W'(ms);
    rel       = pos_cur - tstart;
    blk_start = (pos_cur == '0);
    blk_end   = (pos_cur == blk_len - POS_W'(1));
    crc_en    = (pos_cur < tstart);
    in_tuple  = !crc_en && (rel < tsz);
    tidx      = rel[3:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    pos_q <= '0;
    else if (fire) pos_q <= blk_end ? '0 : pos_cur + POS_W'(1);
  end

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> $stable(pos_q));
  // R4
  block_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && blk_end) |=> (pos_q == '0));

endmodule

// File: rtl/pi_guard_engine.sv
module pi_guard_engine #(
  parameter bit WIDE = 1'b0
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          step_en,
  input  logic                          blk_start,
  input  logic [7:0]                    din,
  output logic [(WIDE ? 64 : 16)-1:0]   guard
);
  import pi_pkg::*;
  localparam int GW = WIDE ? 64 : 16;
  localparam logic [GW-1:0] INIT = {GW{WIDE}};

  logic [GW-1:0] crc_q, crc_cur, crc_nxt;

  assign crc_cur = blk_start ? INIT : crc_q;

  generate
    if (WIDE) begin : g_crc64
      assign crc_nxt = crc64_step(crc_cur, din);
      assign guard   = crc_cur ^ {GW{1'b1}};
    end else begin : g_crc16
      assign crc_nxt = crc16_step(crc_cur, din);
      assign guard   = crc_cur;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)       crc_q <= INIT;
    else if (step_en) crc_q <= crc_nxt;
  end

endmodule

// File: rtl/pi_ref_tag.sv
module pi_ref_tag (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        fire,
  input  logic        first,
  input  logic        blk_end,
  input  logic        wide,
  input  logic [1:0]  ptype,
  input  logic [47:0] start,
  output logic [47:0] ref_cur
);
  logic [47:0] ref_q, mask;

  assign mask    = wide ? 48'hFFFF_FFFF_FFFF : 48'h0000_FFFF_FFFF;
  assign ref_cur = first ? (start & mask) : ref_q;

  always_ff @(posedge clk) begin
    if (!rst_n) ref_q <= '0;
    else if (fire) begin
      if (blk_end && ptype != 2'd3) ref_q <= (ref_cur + 48'd1) & mask;
      else                          ref_q <= ref_cur;
    end
  end

  // R6
  type3_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && blk_end && ptype == 2'd3) |=> (ref_q == $past(ref_cur)));
  // R7
  narrow_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wide |-> (ref_cur[47:32] == 16'h0));

endmodule

// File: rtl/pi_tuple_mux.sv
module pi_tuple_mux (
  input  logic        wide,
  input  logic        zf,
  input  logic        in_tuple,
  input  logic [3:0]  tidx,
  input  logic [15:0] guard16,
  input  logic [63:0] guard64,
  input  logic [15:0] app,
  input  logic [47:0] ref_tag,
  input  logic [7:0]  din,
  output logic [7:0]  dout
);
  import pi_pkg::*;
  logic [63:0]  tup16;
  logic [127:0] tup64;

  always_comb begin
    tup16 = {(zf ? 16'h0 : guard16), app, ref_tag[31:0]};
    tup64 = {(zf ? ZF_GUARD64 : guard64), app, ref_tag};
    if (!in_tuple)  dout = din;
    else if (wide)  dout = tup64[{~tidx, 3'b000} +: 8];
    else            dout = tup16[{~tidx[2:0], 3'b000} +: 8];
  end

endmodule

// File: rtl/pi_tuple_gen.sv
module pi_tuple_gen #(
  parameter int LBS_W = 16,
  parameter int MS_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wide,
  input  logic [1:0]       cfg_type,
  input  logic             cfg_head,
  input  logic             cfg_zero_fill,
  input  logic [LBS_W-1:0] cfg_lbs,
  input  logic [MS_W-1:0]  cfg_ms,
  input  logic [15:0]      cfg_app_tag,
  input  logic [47:0]      cfg_ref_tag,
  input  logic             s_valid,
  output logic             s_ready,
  input  logic [7:0]       s_data,
  input  logic             s_first,
  input  logic             s_last,
  output logic             m_valid,
  input  logic             m_ready,
  output logic [7:0]       m_data,
  output logic             m_last
);
  import pi_pkg::*;

  logic fire;
  cmd_cfg_t cfg_live, cfg_q, cfg_eff;
  logic [LBS_W-1:0] lbs_q, lbs_eff;
  logic [MS_W-1:0]  ms_q, ms_eff;
  logic blk_start, blk_end, crc_en, in_tuple;
  logic [3:0]  tidx;
  logic [15:0] g16;
  logic [63:0] g64;
  logic [47:0] ref_cur;

  assign fire    = s_valid && m_ready;
  assign s_ready = m_ready;
  assign m_valid = s_valid;
  assign m_last  = s_last;

  always_comb begin
    cfg_live = '{wide: cfg_wide, ptype: cfg_type, head: cfg_head,
                 zf: cfg_zero_fill, app: cfg_app_tag};
    cfg_eff  = s_first ? cfg_live : cfg_q;
    lbs_eff  = s_first ? cfg_lbs  : lbs_q;
    ms_eff   = s_first ? cfg_ms   : ms_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= '0;
      lbs_q <= '0;
      ms_q  <= '0;
    end else if (fire && s_first) begin
      cfg_q <= cfg_live;
      lbs_q <= cfg_lbs;
      ms_q  <= cfg_ms;
    end
  end

  pi_pos_ctl #(.LBS_W(LBS_W), .MS_W(MS_W)) u_pos (
    .clk(clk), .rst_n(rst_n), .fire(fire), .first(s_first),
    .lbs(lbs_eff), .ms(ms_eff), .wide(cfg_eff.wide), .head(cfg_eff.head),
    .blk_start(blk_start), .blk_end(blk_end), .crc_en(crc_en),
    .in_tuple(in_tuple), .tidx(tidx)
  );

  pi_guard_engine #(.WIDE(1'b0)) u_g16 (
    .clk(clk), .rst_n(rst_n), .step_en(fire && crc_en),
    .blk_start(blk_start), .din(s_data), .guard(g16)
  );

  pi_guard_engine #(.WIDE(1'b1)) u_g64 (
    .clk(clk), .rst_n(rst_n), .step_en(fire && crc_en),
    .blk_start(blk_start), .din(s_data), .guard(g64)
  );

  pi_ref_tag u_ref (
    .clk(clk), .rst_n(rst_n), .fire(fire), .first(s_first),
    .blk_end(blk_end), .wide(cfg_eff.wide), .ptype(cfg_eff.ptype),
    .start(cfg_ref_tag), .ref_cur(ref_cur)
  );

  pi_tuple_mux u_mux (
    .wide(cfg_eff.wide), .zf(cfg_eff.zf), .in_tuple(in_tuple), .tidx(tidx),
    .guard16(g16), .guard64(g64), .app(cfg_eff.app), .ref_tag(ref_cur),
    .din(s_data), .dout(m_data)
  );

  // R8
  zero_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && cfg_eff.zf && !cfg_eff.wide && in_tuple && tidx < 4'd2) |-> (m_data == 8'h00));
  // R1
  pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && !in_tuple) |-> (m_data == s_data));

endmodule

// File: tb/test_pi_tuple_gen.sv
`timescale 1ns/1ps
module test_pi_tuple_gen;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_wide, cfg_head, cfg_zero_fill;
  logic [1:0] cfg_type;
  logic [15:0] cfg_lbs;
  logic [7:0] cfg_ms;
  logic [15:0] cfg_app_tag;
  logic [47:0] cfg_ref_tag;
  logic s_valid, s_ready, s_first, s_last, m_valid, m_ready, m_last;
  logic [7:0] s_data, m_data;

  always #10 clk = ~clk;

  pi_tuple_gen i_pi_tuple_gen (.*);

  int n_cmp = 0, n_bad = 0;
  logic g_wide, g_head, g_zf;
  logic [1:0] g_type;
  int g_lbs, g_ms;
  logic [15:0] g_app;
  logic [47:0] g_ref;
  string g_reflbl = "R6";
  logic [7:0] in_b [0:1023];
  logic [7:0] exp_b [0:1023];
  string exp_t [0:1023];

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  function automatic logic [15:0] m_crc16(int base, int n);
    logic [15:0] c = 16'h0;
    for (int i = 0; i < n; i++)
      for (int b = 7; b >= 0; b--) begin
        logic fb = c[15] ^ in_b[base+i][b];
        c = c << 1;
        if (fb) c = c ^ 16'h8BB7;
      end
    return c;
  endfunction

  function automatic logic [63:0] m_crc64(int base, int n);
    logic [63:0] c = '1;
    for (int i = 0; i < n; i++)
      for (int b = 0; b < 8; b++) begin
        logic fb = c[0] ^ in_b[base+i][b];
        c = c >> 1;
        if (fb) c = c ^ 64'h9A6C9329AC4BC9B5;
      end
    return ~c;
  endfunction

  task automatic build(int nblk, bit ascii);
    int blen = g_lbs + g_ms;
    int tsz  = g_wide ? 16 : 8;
    int tst  = g_lbs + (g_head ? 0 : g_ms - tsz);
    logic [47:0] mask = g_wide ? 48'hFFFF_FFFF_FFFF : 48'hFFFF_FFFF;
    logic [47:0] r = g_ref & mask;
    for (int b = 0; b < nblk; b++) begin
      int base = b * blen;
      logic [15:0] g16;
      logic [63:0] g64;
      logic [127:0] tv;
      for (int i = 0; i < blen; i++) begin
        in_b[base+i]  = (ascii && i < g_lbs) ? 8'(8'h31 + i % 9) : 8'($urandom);
        exp_b[base+i] = in_b[base+i];
        exp_t[base+i] = (i < g_lbs) ? "R1 data" : "R4 metadata";
      end
      g16 = g_zf ? 16'h0 : m_crc16(base, tst);
      g64 = g_zf ? 64'h6482D367EB22B64E : m_crc64(base, tst);
      tv  = g_wide ? {g64, g_app, r} : {g16, g_app, r[31:0], 64'h0};
      for (int k = 0; k < tsz; k++) begin
        exp_b[base+tst+k] = tv[127-8*k -: 8];
        if (k < (g_wide ? 8 : 2))       exp_t[base+tst+k] = g_zf ? "R8 guard" : (g_wide ? "R3 guard" : "R2 guard");
        else if (k < (g_wide ? 10 : 4)) exp_t[base+tst+k] = "R5 app tag";
        else                            exp_t[base+tst+k] = g_reflbl;
      end
      if (g_type != 2'd3) r = (r + 48'd1) & mask;
    end
  endtask

  task automatic send(int i, int blen);
    bit acc = 0;
    s_valid = 1'b1; s_data = in_b[i]; s_first = (i == 0);
    s_last = ((i % blen) == blen - 1);
    if (s_first) begin
      cfg_wide = g_wide; cfg_head = g_head; cfg_zero_fill = g_zf; cfg_type = g_type;
      cfg_lbs = 16'(g_lbs); cfg_ms = 8'(g_ms); cfg_app_tag = g_app; cfg_ref_tag = g_ref;
    end else begin  // R9: garbage on config pins after the first byte
      cfg_wide = 1'($urandom); cfg_head = 1'($urandom); cfg_zero_fill = 1'($urandom);
      cfg_type = 2'($urandom); cfg_lbs = 16'($urandom); cfg_ms = 8'($urandom);
      cfg_app_tag = 16'($urandom); cfg_ref_tag = {16'($urandom), 32'($urandom)};
    end
    while (!acc) begin
      m_ready = ($urandom % 4) != 0;
      #1;
      chk(s_ready == m_ready, "R10 ready follows", 64'(s_ready), 64'(m_ready));
      if (m_ready) begin
        chk(m_data == exp_b[i], exp_t[i], 64'(m_data), 64'(exp_b[i]));
        chk(m_last == s_last && m_valid, "R1 last/valid", 64'({m_valid, m_last}), 64'({1'b1, s_last}));
        acc = 1;
      end
      @(negedge clk);
    end
  endtask

  task automatic run(bit w, logic [1:0] t, bit h, bit z, int lbs, int ms,
                     logic [15:0] app, logic [47:0] rt, int nblk, bit ascii);
    g_wide = w; g_type = t; g_head = h; g_zf = z; g_lbs = lbs; g_ms = ms;
    g_app = app; g_ref = rt;
    build(nblk, ascii);
    for (int i = 0; i < nblk * (lbs + ms); i++) begin
      if ($urandom % 8 == 0) begin
        s_valid = 1'b0; m_ready = 1'($urandom);
        #1;
        chk(!m_valid, "R1 idle valid", 64'(m_valid), 64'h0);
        @(negedge clk);
      end
      send(i, lbs + ms);
    end
    s_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    s_valid = 0; s_data = 0; s_first = 0; s_last = 0; m_ready = 1;
    cfg_wide = 0; cfg_head = 0; cfg_zero_fill = 0; cfg_type = 1;
    cfg_lbs = 1; cfg_ms = 8; cfg_app_tag = 0; cfg_ref_tag = 0;
    repeat (3) @(negedge clk);
    #1;
    chk(!m_valid && s_ready, "R1 reset state", 64'({m_valid, s_ready}), 64'h1);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 / R3: check values of the guard CRCs
    g_lbs = 9; g_ms = 0; build(1, 1'b1);
    chk(m_crc16(0, 9) == 16'hD0DB, "R2 model check", 64'(m_crc16(0, 9)), 64'hD0DB);
    chk(m_crc64(0, 9) == 64'hAE8B14860A799888, "R3 model check", m_crc64(0, 9), 64'hAE8B14860A799888);
    run(0, 1, 1, 0, 9, 8,  16'hA5C3, 48'h0000_0102_0304, 1, 1'b1);  // R2 head
    run(1, 1, 1, 0, 9, 16, 16'h1234, 48'hABCD_0102_0304, 1, 1'b1);  // R3 head
    run(0, 2, 0, 0, 32, 16, 16'hBEEF, 48'h0000_0000_0010, 3, 1'b0); // R4 tail, R6 increment
    run(1, 3, 0, 0, 24, 24, 16'h0F0F, 48'h1111_2222_3333, 3, 1'b0); // R6 type 3 hold
    g_reflbl = "R7 wrap";
    run(0, 1, 1, 0, 4, 8,  16'h5555, 48'h1234_FFFF_FFFE, 3, 1'b0);  // R7 narrow wrap
    run(1, 2, 0, 0, 4, 20, 16'h6666, 48'hFFFF_FFFF_FFFF, 2, 1'b0);  // R7 wide wrap
    g_reflbl = "R6";
    run(0, 1, 0, 1, 16, 12, 16'h7777, 48'h0000_0000_0100, 2, 1'b0); // R8 narrow
    run(1, 1, 1, 1, 16, 16, 16'h8888, 48'h0000_0000_0200, 2, 1'b0); // R8 wide
    for (int c = 0; c < 30; c++) begin  // R9 / R10 random commands
      bit w = 1'($urandom);
      run(w, 2'(1 + $urandom % 3), 1'($urandom), 1'($urandom % 4 == 0),
          1 + $urandom % 64, (w ? 16 : 8) + $urandom % 17, 16'($urandom),
          {16'($urandom), 32'($urandom)}, 1 + $urandom % 4, 1'b0);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule